// File: doc/BRIEF.md
# USB Receive Endpoint Packet Buffer

This block is the receive-side storage of one OUT endpoint in a USB device controller. It keeps whole data packets, not loose bytes. The storage has two packet slots. A configuration input picks whether one slot or both are in use. The USB side streams the bytes of a packet and then marks the packet's end, with a flag that says whether the packet failed its CRC or bit-stuff check. The CPU side sees a small control/status register, a byte read port, the length of the packet it is reading, and a sticky endpoint interrupt flag.

The CPU takes packets in arrival order. A packet is released in one of three ways: by software writing the ready bit to 0, by a flush, or by auto-clear once max-packet-size bytes have been read. In isochronous mode, packets with errors are kept and marked, and a packet that finds no room is counted as an overrun. In bulk mode, damaged packets are dropped in silence, and a packet that finds no room is refused with a NAK pulse.

Top module: `rxep_buffer`

## Requirements
- R1: After reset the register reads 0, the interrupt flag is 0, the NAK output is 0 and the packet length reads 0.
- R2: In the second cycle after the end strobe of an accepted packet, ready (register bit 0) reads 1 and the length output gives its byte count. Its bytes come out of the read port in arrival order, one per read strobe.
- R3: With auto-clear off, ready stays 1 after the whole packet has been read. A register write with bit 0 = 0 releases the packet. A write with bit 0 = 1 and flush = 0 changes nothing.
- R4: With auto-clear on, ready drops by itself on the read strobe that takes byte number max-packet-size. A shorter packet keeps ready at 1 after all its bytes are read.
- R5: A write with flush (bit 4) = 1 while ready is 1 discards exactly one packet. Two flushes are needed to empty two stored packets. A flush while ready is 0 has no effect.
- R6: Full (bit 2) reads 1 when the number of stored packets equals the capacity: 1 with single buffering, 2 with double buffering.
- R7: In bulk mode, a packet that starts while the buffer is full gives a one-cycle NAK pulse after its end strobe. It is not stored, does not set overrun, and leaves the stored packet intact.
- R8: In isochronous mode, such a packet sets overrun (bit 3), and overrun stays set until a write with bit 3 = 0.
- R9: In isochronous mode, a packet ending with the error flag is stored. Data-error (bit 1) reads 1 while it is the ready packet and 0 once it is released.
- R10: In bulk mode, a packet ending with the error flag is discarded, and data-error and overrun always read 0.
- R11: When a second packet is waiting, ready reads 1 again one cycle after the release, with that packet's length and bytes. An end strobe and a release in the same cycle neither lose nor duplicate a packet.
- R12: The interrupt flag sets in the same cycle ready rises and stays set until an acknowledge pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_iso | input | 1 | 1 = isochronous, 0 = bulk |
| cfg_autoclr | input | 1 | Enable auto-release at max packet size |
| cfg_dbl | input | 1 | 1 = two packet slots, 0 = one |
| cfg_maxp | input | 11 | Max packet size in bytes |
| usb_wr_valid | input | 1 | Packet byte present |
| usb_wr_byte | input | 8 | Packet byte |
| usb_pkt_end | input | 1 | End of packet (carries no byte) |
| usb_pkt_bad | input | 1 | CRC or bit-stuff error, qualified by usb_pkt_end |
| usb_nak | output | 1 | Packet refused (bulk, no room) |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 5 | Register write data |
| csr_rdata | output | 5 | Register: 0 ready, 1 data-error, 2 full, 3 overrun, 4 flush (reads 0) |
| cpu_rd_en | input | 1 | Read strobe, advances the read pointer |
| cpu_rd_byte | output | 8 | Byte at the read pointer |
| rx_count | output | 11 | Length of the ready packet, 0 when not ready |
| irq_ack | input | 1 | Clears the interrupt flag |
| irq_pend | output | 1 | Endpoint receive interrupt flag |

## Verification
Two events can meet in one cycle: the USB side ending a packet, and the CPU releasing the packet it holds. The bench times the release write to land on the same edge as the end strobe. The stored-packet count must then stay at one. Ready must fall for a cycle and come back with the new packet's length and bytes, and full must read 0. A second release must leave the buffer empty, which shows no packet was duplicated.

// File: rtl/rxep_pkg.sv
package rxep_pkg;
    localparam int BYTE_W    = 8;
    localparam int MAXP_W    = 11;
    localparam int CSR_W     = 5;
    localparam int CSR_RDY   = 0;
    localparam int CSR_DERR  = 1;
    localparam int CSR_FULL  = 2;
    localparam int CSR_OVR   = 3;
    localparam int CSR_FLUSH = 4;
endpackage

// File: rtl/rxep_slot_mem.sv
module rxep_slot_mem #(
    parameter int SLOTS     = 2,
    parameter int PKT_BYTES = 64,
    localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int IDX_W    = (PKT_BYTES > 1) ? $clog2(PKT_BYTES) : 1
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [SLOT_W-1:0]          wr_slot,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [rxep_pkg::BYTE_W-1:0] wr_byte,
    input  logic [SLOT_W-1:0]          rd_slot,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [rxep_pkg::BYTE_W-1:0] rd_byte
);
    logic [rxep_pkg::BYTE_W-1:0] slot_out [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [rxep_pkg::BYTE_W-1:0] bytes_q [PKT_BYTES];

        always_ff @(posedge clk) begin
            if (we && (wr_slot == SLOT_W'(g))) begin
                bytes_q[wr_idx] <= wr_byte;
            end
        end

        assign slot_out[g] = bytes_q[rd_idx];
    end

    assign rd_byte = slot_out[rd_slot];
endmodule

// File: rtl/rxep_fill.sv
module rxep_fill #(
    parameter int SLOTS     = 2,
    parameter int PKT_BYTES = 64,
    localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int IDX_W    = (PKT_BYTES > 1) ? $clog2(PKT_BYTES) : 1,
    localparam int PTR_W    = $clog2(PKT_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_iso,
    input  logic               full,
    input  logic               wr_valid,
    input  logic               pkt_end,
    input  logic               pkt_bad,
    output logic               mem_we,
    output logic [SLOT_W-1:0]  mem_slot,
    output logic [IDX_W-1:0]   mem_idx,
    output logic               commit,
    output logic [PTR_W-1:0]   commit_len,
    output logic               commit_err,
    output logic               ovr_set,
    output logic               nak
);
    typedef struct packed {
        logic              in_pkt;
        logic              dropping;
        logic [PTR_W-1:0]  wr_ptr;
        logic [SLOT_W-1:0] wr_slot;
        logic              nak;
    } fill_t;

    fill_t fill_q, fill_d;
    logic  drop_now;
    logic  has_room;

    always_comb begin
        fill_d   = fill_q;
        fill_d.nak = 1'b0;
        drop_now = fill_q.in_pkt ? fill_q.dropping : full;
        has_room = fill_q.wr_ptr < PTR_W'(PKT_BYTES);
        mem_we   = wr_valid && !pkt_end && !drop_now && has_room;
        commit   = pkt_end && !drop_now && !(pkt_bad && !cfg_iso);
        ovr_set  = pkt_end && drop_now && cfg_iso;

        if (wr_valid && !pkt_end) begin
            fill_d.in_pkt   = 1'b1;
            fill_d.dropping = drop_now;
            if (mem_we) begin
                fill_d.wr_ptr = fill_q.wr_ptr + PTR_W'(1);
            end
        end

        if (pkt_end) begin
            fill_d.in_pkt   = 1'b0;
            fill_d.dropping = 1'b0;
            fill_d.wr_ptr   = '0;
            fill_d.nak      = drop_now && !cfg_iso;
            if (commit) begin
                fill_d.wr_slot = (fill_q.wr_slot == SLOT_W'(SLOTS - 1)) ?
                                 '0 : fill_q.wr_slot + SLOT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else begin
            fill_q <= fill_d;
        end
    end

    assign mem_slot   = fill_q.wr_slot;
    assign mem_idx    = fill_q.wr_ptr[IDX_W-1:0];
    assign commit_len = fill_q.wr_ptr;
    assign commit_err = pkt_bad && cfg_iso;
    assign nak        = fill_q.nak;
endmodule

// File: rtl/rxep_ctrl.sv
module rxep_ctrl #(
    parameter int SLOTS     = 2,
    parameter int PKT_BYTES = 64,
    localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int IDX_W    = (PKT_BYTES > 1) ? $clog2(PKT_BYTES) : 1,
    localparam int PTR_W    = $clog2(PKT_BYTES + 1),
    localparam int CNT_W    = $clog2(SLOTS + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_iso,
    input  logic                              cfg_autoclr,
    input  logic                              cfg_dbl,
    input  logic [rxep_pkg::MAXP_W-1:0]       cfg_maxp,
    input  logic                              commit,
    input  logic [PTR_W-1:0]                  commit_len,
    input  logic                              commit_err,
    input  logic                              ovr_set,
    input  logic                              csr_wr,
    input  logic [rxep_pkg::CSR_W-1:0]        csr_wdata,
    input  logic                              rd_en,
    input  logic                              irq_ack,
    output logic                              full,
    output logic [SLOT_W-1:0]                 rd_slot,
    output logic [IDX_W-1:0]                  rd_idx,
    output logic [rxep_pkg::CSR_W-1:0]        csr_rdata,
    output logic [rxep_pkg::MAXP_W-1:0]       rx_count,
    output logic                              irq_pend
);
    import rxep_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0]              count;
        logic [SLOT_W-1:0]             rd_slot;
        logic [PTR_W-1:0]              rd_ptr;
        logic                          ready;
        logic                          over;
        logic                          irq;
        logic [SLOTS-1:0][PTR_W-1:0]   len;
        logic [SLOTS-1:0]              err;
    } ctrl_t;

    ctrl_t             st_q, st_d;
    logic [CNT_W-1:0]  cap;
    logic              rd_fire;
    logic              auto_rel;
    logic              sw_rel;
    logic              release_pkt;
    logic [SLOT_W-1:0] in_slot;
    int unsigned       slot_sum;

    always_comb begin
        st_d        = st_q;
        cap         = cfg_dbl ? CNT_W'(SLOTS) : CNT_W'(1);
        rd_fire     = rd_en && st_q.ready;
        auto_rel    = rd_fire && cfg_autoclr &&
                      ((MAXP_W'(st_q.rd_ptr) + MAXP_W'(1)) == cfg_maxp);
        sw_rel      = csr_wr && st_q.ready &&
                      (csr_wdata[CSR_FLUSH] || !csr_wdata[CSR_RDY]);
        release_pkt = auto_rel || sw_rel;

        slot_sum = int'(st_q.rd_slot) + int'(st_q.count);
        if (slot_sum >= SLOTS) begin
            slot_sum = slot_sum - SLOTS;
        end
        in_slot = SLOT_W'(slot_sum);

        if (commit) begin
            st_d.len[in_slot] = commit_len;
            st_d.err[in_slot] = commit_err;
        end

        st_d.count = st_q.count + CNT_W'(commit) - CNT_W'(release_pkt);

        if (release_pkt) begin
            st_d.rd_ptr  = '0;
            st_d.rd_slot = (st_q.rd_slot == SLOT_W'(SLOTS - 1)) ?
                           '0 : st_q.rd_slot + SLOT_W'(1);
        end else if (rd_fire) begin
            st_d.rd_ptr = st_q.rd_ptr + PTR_W'(1);
        end

        st_d.ready = !release_pkt && (st_q.count != '0);

        if (!st_q.ready && st_d.ready) begin
            st_d.irq = 1'b1;
        end else if (irq_ack) begin
            st_d.irq = 1'b0;
        end

        if (ovr_set) begin
            st_d.over = 1'b1;
        end else if (csr_wr && !csr_wdata[CSR_OVR]) begin
            st_d.over = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full    = st_q.count >= cap;
    assign rd_slot = st_q.rd_slot;
    assign rd_idx  = st_q.rd_ptr[IDX_W-1:0];

    always_comb begin
        csr_rdata            = '0;
        csr_rdata[CSR_RDY]   = st_q.ready;
        csr_rdata[CSR_DERR]  = cfg_iso && st_q.ready && st_q.err[st_q.rd_slot];
        csr_rdata[CSR_FULL]  = full;
        csr_rdata[CSR_OVR]   = cfg_iso && st_q.over;
        rx_count = st_q.ready ? MAXP_W'(st_q.len[st_q.rd_slot]) : '0;
    end

    assign irq_pend = st_q.irq;
endmodule

// File: rtl/rxep_buffer.sv
module rxep_buffer #(
    parameter int SLOTS     = 2,
    parameter int PKT_BYTES = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_iso,
    input  logic         cfg_autoclr,
    input  logic         cfg_dbl,
    input  logic [10:0]  cfg_maxp,
    input  logic         usb_wr_valid,
    input  logic [7:0]   usb_wr_byte,
    input  logic         usb_pkt_end,
    input  logic         usb_pkt_bad,
    output logic         usb_nak,
    input  logic         csr_wr,
    input  logic [4:0]   csr_wdata,
    output logic [4:0]   csr_rdata,
    input  logic         cpu_rd_en,
    output logic [7:0]   cpu_rd_byte,
    output logic [10:0]  rx_count,
    input  logic         irq_ack,
    output logic         irq_pend
);
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int IDX_W  = (PKT_BYTES > 1) ? $clog2(PKT_BYTES) : 1;
    localparam int PTR_W  = $clog2(PKT_BYTES + 1);

    logic              full;
    logic              mem_we;
    logic [SLOT_W-1:0] mem_slot;
    logic [IDX_W-1:0]  mem_idx;
    logic              commit;
    logic [PTR_W-1:0]  commit_len;
    logic              commit_err;
    logic              ovr_set;
    logic [SLOT_W-1:0] rd_slot;
    logic [IDX_W-1:0]  rd_idx;

    rxep_fill #(.SLOTS(SLOTS), .PKT_BYTES(PKT_BYTES)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_iso    (cfg_iso),
        .full       (full),
        .wr_valid   (usb_wr_valid),
        .pkt_end    (usb_pkt_end),
        .pkt_bad    (usb_pkt_bad),
        .mem_we     (mem_we),
        .mem_slot   (mem_slot),
        .mem_idx    (mem_idx),
        .commit     (commit),
        .commit_len (commit_len),
        .commit_err (commit_err),
        .ovr_set    (ovr_set),
        .nak        (usb_nak)
    );

    rxep_slot_mem #(.SLOTS(SLOTS), .PKT_BYTES(PKT_BYTES)) u_mem (
        .clk     (clk),
        .we      (mem_we),
        .wr_slot (mem_slot),
        .wr_idx  (mem_idx),
        .wr_byte (usb_wr_byte),
        .rd_slot (rd_slot),
        .rd_idx  (rd_idx),
        .rd_byte (cpu_rd_byte)
    );

    rxep_ctrl #(.SLOTS(SLOTS), .PKT_BYTES(PKT_BYTES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_iso     (cfg_iso),
        .cfg_autoclr (cfg_autoclr),
        .cfg_dbl     (cfg_dbl),
        .cfg_maxp    (cfg_maxp),
        .commit      (commit),
        .commit_len  (commit_len),
        .commit_err  (commit_err),
        .ovr_set     (ovr_set),
        .csr_wr      (csr_wr),
        .csr_wdata   (csr_wdata),
        .rd_en       (cpu_rd_en),
        .irq_ack     (irq_ack),
        .full        (full),
        .rd_slot     (rd_slot),
        .rd_idx      (rd_idx),
        .csr_rdata   (csr_rdata),
        .rx_count    (rx_count),
        .irq_pend    (irq_pend)
    );
endmodule

// File: rtl/rxep_buffer_chk.sv
module rxep_buffer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_iso,
    input logic       usb_pkt_end,
    input logic       usb_nak,
    input logic       csr_wr,
    input logic [4:0] csr_wdata,
    input logic [4:0] csr_rdata,
    input logic       irq_pend
);
    import rxep_pkg::*;

    AST_DERR_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[CSR_DERR] |-> csr_rdata[CSR_RDY]); // R9

    AST_BULK_FLAGS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_iso |-> (!csr_rdata[CSR_DERR] && !csr_rdata[CSR_OVR])); // R10

    AST_FLUSH_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_rdata[CSR_RDY] && csr_wdata[CSR_FLUSH]) |=> !csr_rdata[CSR_RDY]); // R5

    AST_READY_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csr_rdata[CSR_RDY]) |-> irq_pend); // R12

    AST_NAK_AFTER_BULK_END: assert property (@(posedge clk) disable iff (!rst_n)
        usb_nak |-> $past(usb_pkt_end && !cfg_iso)); // R7

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[CSR_OVR] && !(csr_wr && !csr_wdata[CSR_OVR]))
            |=> (csr_rdata[CSR_OVR] || !cfg_iso)); // R8
endmodule

bind rxep_buffer rxep_buffer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_iso     (cfg_iso),
    .usb_pkt_end (usb_pkt_end),
    .usb_nak     (usb_nak),
    .csr_wr      (csr_wr),
    .csr_wdata   (csr_wdata),
    .csr_rdata   (csr_rdata),
    .irq_pend    (irq_pend)
);

// File: tb/rxep_buffer_tb.sv
`timescale 1ns/1ps
module rxep_buffer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_iso = 1'b0, cfg_autoclr = 1'b0, cfg_dbl = 1'b1;
    logic [10:0] cfg_maxp = 11'd64;
    logic        usb_wr_valid = 1'b0, usb_pkt_end = 1'b0, usb_pkt_bad = 1'b0;
    logic [7:0]  usb_wr_byte = '0;
    logic        usb_nak;
    logic        csr_wr = 1'b0;
    logic [4:0]  csr_wdata = '0;
    logic [4:0]  csr_rdata;
    logic        cpu_rd_en = 1'b0;
    logic [7:0]  cpu_rd_byte;
    logic [10:0] rx_count;
    logic        irq_ack = 1'b0;
    logic        irq_pend;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rxep_buffer u_dut (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_pkt(input int n, input int base, input bit bad);
        for (int i = 0; i < n; i++) begin
            usb_wr_valid = 1'b1;
            usb_wr_byte  = 8'(base + i);
            step();
        end
        usb_wr_valid = 1'b0;
        usb_pkt_end  = 1'b1;
        usb_pkt_bad  = bad;
        step();
        usb_pkt_end  = 1'b0;
        usb_pkt_bad  = 1'b0;
    endtask

    task automatic csr_write(input logic [4:0] v);
        csr_wr    = 1'b1;
        csr_wdata = v;
        step();
        csr_wr    = 1'b0;
        csr_wdata = '0;
    endtask

    task automatic read_bytes(input int n, input int base, input string req);
        for (int i = 0; i < n; i++) begin
            chk(req, "read byte", int'(cpu_rd_byte), (base + i) & 8'hff);
            cpu_rd_en = 1'b1;
            step();
            cpu_rd_en = 1'b0;
        end
    endtask

    task automatic ack_irq();
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "csr", int'(csr_rdata), 0);
        chk("R1", "irq", int'(irq_pend), 0);
        chk("R1", "nak", int'(usb_nak), 0);
        chk("R1", "len", int'(rx_count), 0);
    endtask

    task automatic t_basic();
        send_pkt(5, 'h10, 1'b0);
        step();
        chk("R2", "ready", int'(csr_rdata[0]), 1);
        chk("R2", "len", int'(rx_count), 5);
        chk("R12", "irq set", int'(irq_pend), 1);
        read_bytes(5, 'h10, "R2");
        chk("R3", "ready after read", int'(csr_rdata[0]), 1);
        csr_write(5'b00001);
        chk("R3", "write 1 no effect", int'(csr_rdata[0]), 1);
        csr_write(5'b00000);
        chk("R3", "manual clear", int'(csr_rdata[0]), 0);
        step();
        chk("R3", "stays clear", int'(csr_rdata[0]), 0);
        chk("R12", "irq held", int'(irq_pend), 1);
        ack_irq();
        chk("R12", "irq ack", int'(irq_pend), 0);
    endtask

    task automatic t_autoclr();
        cfg_autoclr = 1'b1;
        cfg_maxp    = 11'd4;
        send_pkt(4, 'h20, 1'b0);
        step();
        read_bytes(4, 'h20, "R4");
        chk("R4", "auto clear at maxp", int'(csr_rdata[0]), 0);
        send_pkt(3, 'h30, 1'b0);
        step();
        read_bytes(3, 'h30, "R4");
        chk("R4", "short pkt stays", int'(csr_rdata[0]), 1);
        csr_write(5'b00000);
        step();
        cfg_autoclr = 1'b0;
        cfg_maxp    = 11'd64;
        ack_irq();
    endtask

    task automatic t_flush();
        send_pkt(3, 'h40, 1'b0);
        send_pkt(2, 'h50, 1'b0);
        step();
        chk("R6", "full double", int'(csr_rdata[2]), 1);
        chk("R5", "len first", int'(rx_count), 3);
        csr_write(5'b10001);
        chk("R5", "flush drops ready", int'(csr_rdata[0]), 0);
        step();
        chk("R11", "second ready", int'(csr_rdata[0]), 1);
        chk("R11", "second len", int'(rx_count), 2);
        chk("R5", "second byte", int'(cpu_rd_byte), 'h50);
        chk("R6", "not full", int'(csr_rdata[2]), 0);
        csr_write(5'b10001);
        step();
        chk("R5", "empty after two", int'(csr_rdata[0]), 0);
        csr_write(5'b10001);
        step();
        chk("R5", "idle flush", int'(csr_rdata[0]), 0);
        send_pkt(1, 'h60, 1'b0);
        step();
        chk("R5", "after idle flush len", int'(rx_count), 1);
        chk("R5", "after idle flush byte", int'(cpu_rd_byte), 'h60);
        csr_write(5'b00000);
        step();
        ack_irq();
    endtask

    task automatic t_full_single();
        cfg_dbl = 1'b0;
        send_pkt(2, 'h70, 1'b0);
        step();
        chk("R6", "full single", int'(csr_rdata[2]), 1);
        send_pkt(3, 'h80, 1'b0);
        chk("R7", "nak pulse", int'(usb_nak), 1);
        step();
        chk("R7", "nak ends", int'(usb_nak), 0);
        chk("R7", "no overrun", int'(csr_rdata[3]), 0);
        chk("R7", "len kept", int'(rx_count), 2);
        chk("R7", "byte kept", int'(cpu_rd_byte), 'h70);
        cfg_iso = 1'b1;
        send_pkt(1, 'h90, 1'b0);
        chk("R8", "no nak iso", int'(usb_nak), 0);
        step();
        chk("R8", "overrun set", int'(csr_rdata[3]), 1);
        step();
        chk("R8", "overrun sticky", int'(csr_rdata[3]), 1);
        csr_write(5'b00001);
        chk("R8", "overrun cleared", int'(csr_rdata[3]), 0);
        chk("R8", "ready kept", int'(csr_rdata[0]), 1);
        csr_write(5'b00000);
        step();
        cfg_iso = 1'b0;
        cfg_dbl = 1'b1;
        ack_irq();
    endtask

    task automatic t_errors();
        cfg_iso = 1'b1;
        send_pkt(2, 'hA0, 1'b1);
        step();
        chk("R9", "ready err pkt", int'(csr_rdata[0]), 1);
        chk("R9", "data error", int'(csr_rdata[1]), 1);
        read_bytes(2, 'hA0, "R9");
        csr_write(5'b00000);
        chk("R9", "derr clears", int'(csr_rdata[1]), 0);
        step();
        cfg_iso = 1'b0;
        send_pkt(2, 'hB0, 1'b1);
        step();
        step();
        chk("R10", "bulk bad dropped", int'(csr_rdata[0]), 0);
        send_pkt(1, 'hC0, 1'b0);
        step();
        chk("R10", "next good byte", int'(cpu_rd_byte), 'hC0);
        chk("R10", "next good derr", int'(csr_rdata[1]), 0);
        csr_write(5'b00000);
        step();
        cfg_iso = 1'b1;
        send_pkt(1, 'hD0, 1'b1);
        step();
        chk("R9", "iso derr", int'(csr_rdata[1]), 1);
        cfg_iso = 1'b0;
        step();
        chk("R10", "bulk hides derr", int'(csr_rdata[1]), 0);
        csr_write(5'b00000);
        step();
        ack_irq();
    endtask

    task automatic t_collide();
        send_pkt(2, 'hE0, 1'b0);
        step();
        ack_irq();
        chk("R12", "acked", int'(irq_pend), 0);
        for (int i = 0; i < 3; i++) begin
            usb_wr_valid = 1'b1;
            usb_wr_byte  = 8'('hF0 + i);
            step();
        end
        usb_wr_valid = 1'b0;
        usb_pkt_end  = 1'b1;
        csr_wr       = 1'b1;
        csr_wdata    = 5'b00000;
        step();
        usb_pkt_end  = 1'b0;
        csr_wr       = 1'b0;
        chk("R11", "gap cycle", int'(csr_rdata[0]), 0);
        step();
        chk("R11", "new ready", int'(csr_rdata[0]), 1);
        chk("R11", "new len", int'(rx_count), 3);
        chk("R11", "new byte", int'(cpu_rd_byte), 'hF0);
        chk("R11", "one stored", int'(csr_rdata[2]), 0);
        chk("R12", "irq again", int'(irq_pend), 1);
        csr_write(5'b00000);
        step();
        chk("R11", "empty after", int'(csr_rdata[0]), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_autoclr();
        t_flush();
        t_full_single();
        t_errors();
        t_collide();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule